// File: doc/BRIEF.md
# Serial Host Control Register Port

This block is a slave port on a four-wire clocked serial link driven by a host microcontroller. The four lines are chip-enable, serial clock, data-in and an open-drain data-out. All three host lines pass through two-flop synchronizers on the fast system clock. Every decision is then made on the system clock, from edges detected on the synchronized serial clock. While chip-enable is high, the host sends bytes least significant bit first, one bit on each rising serial clock edge.

A write transaction has two bytes. The first byte is a command code and the second byte is the data. A command whose low nibble is zero chooses a control register through its high nibble. This gives up to twelve 8-bit registers, and each one has its own reset default and its own bits held at zero. The register contents go to the rest of the chip on a flat bus.

Bit 7 of register 0 is a software reset request. The rest of the display logic uses it to force a blue background screen. Writing a 1 to it produces a one-clock reset pulse, and the bit then clears itself. A separate command code reads a packed status byte back over the open-drain line, during the second byte of the transaction.

Top module: `host_reg_port`

## Requirements
- R1: After reset, register i, which appears at `reg_flat[8*i+7:8*i]`, holds 0x60 for i=0, 0x03 for i=2, 0x0A for i=5 and 0x00 for every other index (0..11). `soft_rst_pulse` and `ser_do_low` are low.
- R2: A transaction of 16 bits sent LSB first has a command byte `c` with `c[3:0]==0` and `c[7:4]<12`. It loads the data byte into register `c[7:4]` after the 16th rising clock edge.
- R3: A command byte with a non-zero low nibble, or with a high nibble of 12 to 15, changes no register. This includes the status read code 0x11.
- R4: Some bits always read 0, whatever data is written: bits 7:4 of registers 5 and 7, bit 5 of register 8, and bits 7:5 of register 10.
- R5: Dropping chip-enable before the 16th rising edge discards the transaction. So does dropping it in the same system cycle as that edge. Rising edges after the 16th are ignored until chip-enable drops.
- R6: Writing register 0 with data bit 7 set raises `soft_rst_pulse` for exactly one system clock. After that, register 0 bit 7 reads 0 and bits 6:0 keep the written data.
- R7: For command 0x11, the status byte is captured when the command byte completes. Before the k-th rising edge of the second byte (k=0..7), `ser_do_low` is high exactly when status bit k is 0. The status packing, from bit 7 down to bit 0, is: `p_flag[1]`, `p_flag[0]`, `q_flag[1]`, `q_flag[0]`, `disc_gfx`, `vblank`, `cmd_idle`, `data_ready`.
- R8: `ser_do_low` stays low outside the data byte of a status read. This covers the command byte, write transactions, and the time when chip-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_ce | input | 1 | Host chip-enable, active high |
| ser_clk | input | 1 | Host serial clock |
| ser_di | input | 1 | Host serial data into the block |
| p_flag | input | 2 | P error-correction flags 1 and 0 |
| q_flag | input | 2 | Q error-correction flags 1 and 0 |
| disc_gfx | input | 1 | Disc carries graphics |
| vblank | input | 1 | Vertical blanking in progress |
| cmd_idle | input | 1 | Graphics command engine waiting |
| data_ready | input | 1 | Readable data available |
| ser_do_low | output | 1 | Open-drain pull-down enable for the data-out line |
| reg_flat | output | 96 | Control register contents, register i at bits 8i+7..8i |
| soft_rst_pulse | output | 1 | One-cycle software reset request |

## Verification
Two events can fall in the same system cycle: the 16th serial clock rising edge that commits a write, and the fall of chip-enable that aborts a transaction. The bench drives both lines in one system clock. Because the two synchronizer paths have equal length, both events reach the frame logic together, and the bench then expects every register to keep its previous value. A second overlap can occur in a status read, when the status inputs change while the data byte is being shifted out. The bench changes the flags right after the command byte and judges the output against the byte captured earlier.

// File: rtl/host_reg_port_pkg.sv
package host_reg_port_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned MAX_REGS  = 16;
  localparam logic [7:0]  STATUS_RD = 8'h11;

  function automatic logic [7:0] reg_reset_value(input int unsigned idx);
    case (idx)
      0:       return 8'h60;
      2:       return 8'h03;
      5:       return 8'h0A;
      default: return 8'h00;
    endcase
  endfunction

  // bits that are held at zero whatever the host writes
  function automatic logic [7:0] reg_fixed_zero(input int unsigned idx);
    case (idx)
      5, 7:    return 8'hF0;
      8:       return 8'h20;
      10:      return 8'hE0;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic cmd_is_write(input logic [7:0] c, input int unsigned nregs);
    return (c[3:0] == 4'h0) && (32'(c[7:4]) < nregs);
  endfunction

  function automatic logic [7:0] pack_status(input logic [1:0] pf, input logic [1:0] qf,
                                             input logic dg, input logic vb,
                                             input logic idle, input logic rdy);
    return {pf[1], pf[0], qf[1], qf[0], dg, vb, idle, rdy};
  endfunction
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hrp_frame.sv
module hrp_frame
  import host_reg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_s,
  input  logic       sck_s,
  input  logic       di_s,
  input  logic [7:0] status_byte,
  output logic       sck_rise,
  output logic       wr_strobe,
  output logic [7:0] wr_cmd,
  output logic [7:0] wr_data,
  output logic       do_low
);
  localparam int unsigned FRAME_BITS = 2 * REG_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

  logic             sck_q;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       shreg;
  logic [7:0]       shnext;
  logic [7:0]       snap;
  logic             rd_mode;

  assign sck_rise = sck_s & ~sck_q;
  assign shnext   = {di_s, shreg[7:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      snap      <= '0;
      rd_mode   <= 1'b0;
      wr_strobe <= 1'b0;
      wr_cmd    <= '0;
      wr_data   <= '0;
    end else begin
      sck_q     <= sck_s;
      wr_strobe <= 1'b0;
      if (!ce_s) begin
        bit_cnt <= '0;
        rd_mode <= 1'b0;
      end else if (sck_rise && (32'(bit_cnt) < FRAME_BITS)) begin
        shreg   <= shnext;
        bit_cnt <= bit_cnt + 1'b1;
        if (32'(bit_cnt) == REG_W - 1) begin
          wr_cmd  <= shnext;
          rd_mode <= (shnext == STATUS_RD);
          snap    <= status_byte;
        end
        if (32'(bit_cnt) == FRAME_BITS - 1) begin
          wr_strobe <= 1'b1;
          wr_data   <= shnext;
        end
      end
    end
  end

  // data byte of a read: bit_cnt 8..15 selects the snapshot bit on the line
  assign do_low = rd_mode && (bit_cnt[CNT_W-1:3] == 2'b01) && !snap[bit_cnt[2:0]];
endmodule

// File: rtl/hrp_regbank.sv
module hrp_regbank
  import host_reg_port_pkg::*;
#(
  parameter int unsigned NUM_REGS = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_strobe,
  input  logic [7:0]                wr_cmd,
  input  logic [7:0]                wr_data,
  output logic [NUM_REGS*REG_W-1:0] reg_flat,
  output logic                      soft_rst
);
  logic wr_ok;
  assign wr_ok = wr_strobe && cmd_is_write(wr_cmd, NUM_REGS);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= reg_reset_value(g);
      end else if (wr_ok && (wr_cmd[7:4] == 4'(g))) begin
        q <= wr_data & ~reg_fixed_zero(g);
      end else if (g == 0) begin
        q[7] <= 1'b0;  // reset request lives for one clock
      end
    end
    assign reg_flat[g*REG_W +: REG_W] = q;
  end

  assign soft_rst = reg_flat[7];
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
  import host_reg_port_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_ce,
  input  logic                      ser_clk,
  input  logic                      ser_di,
  input  logic [1:0]                p_flag,
  input  logic [1:0]                q_flag,
  input  logic                      disc_gfx,
  input  logic                      vblank,
  input  logic                      cmd_idle,
  input  logic                      data_ready,
  output logic                      ser_do_low,
  output logic [NUM_REGS*REG_W-1:0] reg_flat,
  output logic                      soft_rst_pulse
);
  logic [2:0] lines_s;
  logic       ce_s;
  logic       sck_s;
  logic       di_s;
  logic       sck_rise;
  logic       wr_strobe;
  logic [7:0] wr_cmd;
  logic [7:0] wr_data;
  logic [7:0] status_byte;

  hrp_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_ce, ser_clk, ser_di}), .q(lines_s)
  );
  assign {ce_s, sck_s, di_s} = lines_s;

  assign status_byte = pack_status(p_flag, q_flag, disc_gfx, vblank, cmd_idle, data_ready);

  hrp_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ce_s), .sck_s(sck_s), .di_s(di_s),
    .status_byte(status_byte),
    .sck_rise(sck_rise),
    .wr_strobe(wr_strobe), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .do_low(ser_do_low)
  );

  hrp_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_strobe(wr_strobe), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .reg_flat(reg_flat), .soft_rst(soft_rst_pulse)
  );
endmodule

// File: rtl/host_reg_port_chk.sv
module host_reg_port_chk
  import host_reg_port_pkg::*;
#(
  parameter int unsigned NUM_REGS = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ce_s,
  input logic                      wr_strobe,
  input logic [7:0]                wr_cmd,
  input logic                      ser_do_low,
  input logic [NUM_REGS*REG_W-1:0] reg_flat,
  input logic                      soft_rst_pulse
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_fz
    p_fixed_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_flat[g*REG_W +: REG_W] & reg_fixed_zero(g)) == 8'h00);
  end

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |=> !soft_rst_pulse);

  p_pulse_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |=> !reg_flat[7]);

  p_hold_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |=> ($stable(reg_flat[NUM_REGS*REG_W-1:8]) && $stable(reg_flat[6:0])));

  p_bad_code_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && (wr_cmd[3:0] != 4'h0)) |=>
      ($stable(reg_flat[NUM_REGS*REG_W-1:8]) && $stable(reg_flat[6:0])));

  p_abort_no_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !wr_strobe);

  p_do_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !ser_do_low);
endmodule

bind host_reg_port host_reg_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_s(ce_s),
  .wr_strobe(wr_strobe), .wr_cmd(wr_cmd),
  .ser_do_low(ser_do_low), .reg_flat(reg_flat),
  .soft_rst_pulse(soft_rst_pulse)
);

// File: tb/test_host_reg_port.sv
`timescale 1ns/1ps
module test_host_reg_port;
  localparam int NR = 12;
  localparam int H  = 110;  // serial half period in system clocks (440 ns)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_ce = 1'b0, ser_clk = 1'b0, ser_di = 1'b0;
  logic [7:0] stat_v = 8'h00;
  logic ser_do_low;
  logic [NR*8-1:0] reg_flat;
  logic soft_rst_pulse;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;
  logic [7:0] exp_r [NR];
  int exp_pulses = 0;

  always #2 clk = ~clk;

  host_reg_port i_host_reg_port (
    .clk(clk), .rst_n(rst_n), .ser_ce(ser_ce), .ser_clk(ser_clk), .ser_di(ser_di),
    .p_flag(stat_v[7:6]), .q_flag(stat_v[5:4]), .disc_gfx(stat_v[3]),
    .vblank(stat_v[2]), .cmd_idle(stat_v[1]), .data_ready(stat_v[0]),
    .ser_do_low(ser_do_low), .reg_flat(reg_flat), .soft_rst_pulse(soft_rst_pulse)
  );

  always @(posedge clk) if (rst_n && soft_rst_pulse) pulses++;

  function automatic logic [7:0] b_default(int i);
    if (i == 0) return 8'h60;
    if (i == 2) return 8'h03;
    if (i == 5) return 8'h0A;
    return 8'h00;
  endfunction

  function automatic logic [7:0] b_writable(int i);
    if (i == 5 || i == 7) return 8'h0F;
    if (i == 8)  return 8'hDF;
    if (i == 10) return 8'h1F;
    return 8'hFF;
  endfunction

  task automatic model_write(input logic [7:0] c, input logic [7:0] d);
    int idx;
    idx = int'(c[7:4]);
    if (c[3:0] == 4'h0 && idx < NR) begin
      exp_r[idx] = d & b_writable(idx);
      if (idx == 0) begin
        if (d[7]) exp_pulses++;
        exp_r[0][7] = 1'b0;
      end
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < NR; i++)
      chk(reg_flat[i*8 +: 8] == exp_r[i], tag, 32'(reg_flat[i*8 +: 8]), 32'(exp_r[i]));
    chk(pulses == exp_pulses, {tag, " pulses R6"}, pulses, exp_pulses);
  endtask

  // nbits bits of {b1,b0}, then zeros; rd compares the data byte against rd_exp
  task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input int nbits,
                      input bit rd, input logic [7:0] rd_exp, input logic [7:0] st_after,
                      input bit clash);
    logic bv;
    @(negedge clk) ser_ce = 1'b1;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      bv = (i < 8) ? b0[i] : ((i < 16) ? b1[i-8] : 1'b0);
      ser_di = bv;
      repeat (H) @(negedge clk);
      if (rd && i >= 8 && i < 16)
        chk(ser_do_low == !rd_exp[i-8], "R7 read bit", 32'(ser_do_low), 32'(!rd_exp[i-8]));
      else
        chk(ser_do_low == 1'b0, "R8 line quiet", 32'(ser_do_low), 0);
      ser_clk = 1'b1;
      if (clash && i == nbits - 1) ser_ce = 1'b0;
      repeat (H) @(negedge clk);
      ser_clk = 1'b0;
      if (i == 7) stat_v = st_after;
    end
    repeat (H) @(negedge clk);
    ser_ce = 1'b0;
    repeat (20) @(negedge clk);
    chk(ser_do_low == 1'b0, "R8 idle", 32'(ser_do_low), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] c, d, s;
    void'($urandom(32'd2024));
    for (int i = 0; i < NR; i++) exp_r[i] = b_default(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_regs("R1 reset");
    chk(soft_rst_pulse == 1'b0, "R1 pulse idle", 32'(soft_rst_pulse), 0);

    xfer(8'h20, 8'h5A, 16, 0, 8'h00, stat_v, 0); model_write(8'h20, 8'h5A); check_regs("R2 write reg2");
    xfer(8'hB0, 8'hC3, 16, 0, 8'h00, stat_v, 0); model_write(8'hB0, 8'hC3); check_regs("R2 write reg11");
    xfer(8'h50, 8'hFF, 16, 0, 8'h00, stat_v, 0); model_write(8'h50, 8'hFF); check_regs("R4 reg5");
    xfer(8'h80, 8'hFF, 16, 0, 8'h00, stat_v, 0); model_write(8'h80, 8'hFF); check_regs("R4 reg8");
    xfer(8'hA0, 8'hFF, 16, 0, 8'h00, stat_v, 0); model_write(8'hA0, 8'hFF); check_regs("R4 reg10");
    xfer(8'h70, 8'hFF, 16, 0, 8'h00, stat_v, 0); model_write(8'h70, 8'hFF); check_regs("R4 reg7");
    xfer(8'hC0, 8'hAA, 16, 0, 8'h00, stat_v, 0); check_regs("R3 code C0");
    xfer(8'h35, 8'hAA, 16, 0, 8'h00, stat_v, 0); check_regs("R3 low nibble");
    xfer(8'h10, 8'h77, 12, 0, 8'h00, stat_v, 0); check_regs("R5 abort short");
    xfer(8'h40, 8'h99, 16, 0, 8'h00, stat_v, 1); check_regs("R5 clash edge");
    xfer(8'h30, 8'h81, 21, 0, 8'h00, stat_v, 0); model_write(8'h30, 8'h81); check_regs("R5 extra bits");
    xfer(8'h00, 8'h95, 16, 0, 8'h00, stat_v, 0); model_write(8'h00, 8'h95); check_regs("R6 soft reset");
    stat_v = 8'hA5;
    xfer(8'h11, 8'hFF, 16, 1, 8'hA5, 8'h3C, 0); check_regs("R7 read no write");
    stat_v = 8'h00;
    xfer(8'h11, 8'h00, 16, 1, 8'h00, 8'hFF, 0);
    xfer(8'h11, 8'h00, 16, 1, 8'hFF, 8'h00, 0); check_regs("R3 after reads");

    for (int n = 0; n < 18; n++) begin
      d = 8'($urandom);
      if (($urandom % 10) < 7) c = {4'($urandom % NR), 4'h0};
      else if (($urandom % 4) == 0) c = 8'h11;
      else c = 8'($urandom);
      s = 8'($urandom);
      stat_v = s;
      xfer(c, d, 16, (c == 8'h11), s, 8'($urandom), 0);
      model_write(c, d);
      check_regs("R2 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule